// File: doc/BRIEF.md
# DRAM Row, Column and Bank Mapper

This block turns a rank-relative address into the coordinates a DRAM device needs: a row number, a column number, a two-bit bank address and a two-bit bank group. Each output bit is picked from a fixed position of the incoming address. The positions depend on the page policy. Closed-page operation spreads consecutive lines across banks. Open-page operation keeps them in one row. In open-page mode a fine-grain banking option moves one bank-group bit down to a low address bit. An optional hash XORs the bank and bank-group bits with higher address bits, which spreads row-conflict patterns across banks.

The caller states how many row and column bits the device uses. Only that many low-order bits are gathered, and every bit above them reads as zero. The mapping itself is combinational. An optional output register captures the result when the input is marked valid, so the mapper can sit on a pipeline boundary of an error-reporting or address-translation path.

Top module: `dram_addr_mapper`

## Requirements
- R1: After reset, and before any valid input, `out_valid` is 0 and `row`, `col`, `bank` and `bgroup` are all 0.
- R2: In closed-page mode (`close_page`=1), row bit i equals rank-address bit P[i], where P = 15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33 for i = 0..16.
- R3: In open-page mode (`close_page`=0), row bit i equals rank-address bit P[i], where P = 14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33 for i = 0..16.
- R4: In closed-page mode, column bits 0..9 come from address bits 3,4,5,14,19,23,24,25,26,27, in that order. Column bit 10, the auto-precharge bit, is always 1.
- R5: In open-page mode, column bit 10 is 0. Column bits 0..9 come from address bits 3..12 in ascending order when `fine_bank`=0. When `fine_bank`=1 they come from address bits 3,4,5,7,8,9,10,11,12,13.
- R6: The bank address {bank[1],bank[0]} is taken from address bits {9,8} in closed-page mode and {19,18} in open-page mode. When `bank_hash`=1, bits {28,22} (closed) or {23,22} (open) are XORed into it.
- R7: The bank group bit 1 comes from address bit 7 (closed) or address bit 17 (open). Bank group bit 0 comes from address bit 6 in closed-page mode. In open-page mode it comes from address bit 6 when `fine_bank`=1 and from address bit 13 otherwise. When `bank_hash`=1, {bgroup[1],bgroup[0]} is XORed with address bits {21,20} in both modes.
- R8: Only the low `row_bits` row bits and the low `col_bits` column bits (0..9) are gathered, and the gathered bits above those counts are 0. A `row_bits` value above 17 acts as 17, and a `col_bits` value above 10 acts as 10.
- R9: With the output register enabled, the result for an input presented with `in_valid`=1 appears on the outputs one clock later, and `out_valid` is 1 in that cycle. While `in_valid`=0, `row`, `col`, `bank` and `bgroup` hold their last values and `out_valid` is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input address and modes are valid this cycle |
| rank_addr | input | 34 | Rank-relative address |
| close_page | input | 1 | 1 = closed-page bit tables, 0 = open-page tables |
| fine_bank | input | 1 | Fine-grain banking select (open-page only) |
| bank_hash | input | 1 | Enable XOR hashing of bank and bank-group bits |
| row_bits | input | 5 | Number of row bits to gather (clamped to 17) |
| col_bits | input | 4 | Number of column bits to gather (clamped to 10) |
| out_valid | output | 1 | Outputs hold a freshly mapped result |
| row | output | 17 | DRAM row |
| col | output | 11 | DRAM column, bit 10 being auto-precharge |
| bank | output | 2 | Bank address |
| bgroup | output | 2 | Bank group |

## Verification
A single 1 is walked through every address bit in each of the three table variants: closed page, open page, and open page with fine-grain banking. Each output bit must then light up at exactly the listed position, which separates a swapped table entry from a wrong mode select. Random addresses with the hash on and off show the XOR terms apart from the plain bank selection. Reduced, oversized and zero bit counts show masking apart from clamping. A hold pattern changes the inputs with `in_valid` low and checks that the outputs do not move.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  localparam int unsigned POS_W       = 6;
  localparam int unsigned ROW_LIST_N  = 17;
  localparam int unsigned COL_LIST_N  = 10;

  // Address position feeding row bit idx
  function automatic logic [POS_W-1:0] row_pos(input logic closed, input int unsigned idx);
    logic [POS_W-1:0] p;
    p = '0;
    if (closed) begin
      case (idx)
        0: p = 6'd15;  1: p = 6'd16;  2: p = 6'd17;  3: p = 6'd18;
        4: p = 6'd20;  5: p = 6'd21;  6: p = 6'd22;  7: p = 6'd28;
        8: p = 6'd10;  9: p = 6'd11; 10: p = 6'd12; 11: p = 6'd13;
        12: p = 6'd29; 13: p = 6'd30; 14: p = 6'd31; 15: p = 6'd32;
        16: p = 6'd33;
        default: p = '0;
      endcase
    end else begin
      case (idx)
        0: p = 6'd14;  1: p = 6'd15;  2: p = 6'd16;  3: p = 6'd20;
        4: p = 6'd28;  5: p = 6'd21;  6: p = 6'd22;  7: p = 6'd23;
        8: p = 6'd24;  9: p = 6'd25; 10: p = 6'd26; 11: p = 6'd27;
        12: p = 6'd29; 13: p = 6'd30; 14: p = 6'd31; 15: p = 6'd32;
        16: p = 6'd33;
        default: p = '0;
      endcase
    end
    return p;
  endfunction

  // Address position feeding column bit idx
  function automatic logic [POS_W-1:0] col_pos(input logic closed, input logic fine,
                                               input int unsigned idx);
    logic [POS_W-1:0] p;
    p = '0;
    if (closed) begin
      case (idx)
        0: p = 6'd3;  1: p = 6'd4;  2: p = 6'd5;  3: p = 6'd14; 4: p = 6'd19;
        5: p = 6'd23; 6: p = 6'd24; 7: p = 6'd25; 8: p = 6'd26; 9: p = 6'd27;
        default: p = '0;
      endcase
    end else if (fine) begin
      // skips address bit 6, which feeds the bank group instead
      p = (idx < 3) ? POS_W'(idx + 3) : POS_W'(idx + 4);
    end else begin
      p = POS_W'(idx + 3);
    end
    return p;
  endfunction

  function automatic int unsigned clamp_cnt(input int unsigned cnt, input int unsigned lim);
    return (cnt > lim) ? lim : cnt;
  endfunction

endpackage

// File: rtl/dram_bit_gather.sv
module dram_bit_gather #(
  parameter int unsigned ADDR_W = 34,
  parameter int unsigned N      = 17,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [ADDR_W-1:0]                      addr,
  input  logic [N-1:0][dram_map_pkg::POS_W-1:0]  pos,
  input  logic [CNT_W-1:0]                       cnt,
  output logic [N-1:0]                           vec
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vec[i] = (cnt > CNT_W'(i)) ? addr[pos[i]] : 1'b0;
  end
endmodule

// File: rtl/dram_bank_sel.sv
module dram_bank_sel #(
  parameter int unsigned ADDR_W = 34
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              close_page,
  input  logic              fine_bank,
  input  logic              bank_hash,
  output logic [1:0]        bank,
  output logic [1:0]        bgroup
);
  logic [1:0] bank_raw, bank_xor, bg_raw, bg_xor;

  always_comb begin
    if (close_page) begin
      bank_raw = {addr[9], addr[8]};
      bank_xor = {addr[28], addr[22]};
      bg_raw   = {addr[7], addr[6]};
    end else begin
      bank_raw = {addr[19], addr[18]};
      bank_xor = {addr[23], addr[22]};
      bg_raw   = {addr[17], fine_bank ? addr[6] : addr[13]};
    end
    bg_xor = {addr[21], addr[20]};
  end

  assign bank   = bank_hash ? (bank_raw ^ bank_xor) : bank_raw;
  assign bgroup = bank_hash ? (bg_raw ^ bg_xor) : bg_raw;
endmodule

// File: rtl/dram_out_stage.sv
module dram_out_stage #(
  parameter int unsigned W       = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        q         <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) q <= d;
      end
    end

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(q) && !out_valid));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign q         = d;
  end
endmodule

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper #(
  parameter int unsigned ADDR_W  = 34,
  parameter int unsigned ROW_N   = dram_map_pkg::ROW_LIST_N,
  parameter int unsigned COL_N   = dram_map_pkg::COL_LIST_N,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned ROW_CW = $clog2(ROW_N + 15),
  localparam int unsigned COL_CW = $clog2(COL_N + 6),
  localparam int unsigned COL_OW = COL_N + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] rank_addr,
  input  logic              close_page,
  input  logic              fine_bank,
  input  logic              bank_hash,
  input  logic [ROW_CW-1:0] row_bits,
  input  logic [COL_CW-1:0] col_bits,
  output logic              out_valid,
  output logic [ROW_N-1:0]  row,
  output logic [COL_OW-1:0] col,
  output logic [1:0]        bank,
  output logic [1:0]        bgroup
);
  import dram_map_pkg::*;

  localparam int unsigned PACK_W = ROW_N + COL_OW + 4;

  logic [ROW_N-1:0][POS_W-1:0] row_sel;
  logic [COL_N-1:0][POS_W-1:0] col_sel;
  logic [ROW_CW-1:0]           row_cnt;
  logic [COL_CW-1:0]           col_cnt;
  logic [ROW_N-1:0]            row_c;
  logic [COL_N-1:0]            colg_c;
  logic [COL_OW-1:0]           col_c;
  logic [1:0]                  bank_c, bg_c;
  logic [PACK_W-1:0]           pack_c, pack_q;

  always_comb begin
    for (int unsigned i = 0; i < ROW_N; i++) row_sel[i] = row_pos(close_page, i);
    for (int unsigned i = 0; i < COL_N; i++) col_sel[i] = col_pos(close_page, fine_bank, i);
    row_cnt = ROW_CW'(clamp_cnt(int'(row_bits), ROW_N));
    col_cnt = COL_CW'(clamp_cnt(int'(col_bits), COL_N));
  end

  dram_bit_gather #(.ADDR_W(ADDR_W), .N(ROW_N), .CNT_W(ROW_CW)) u_row (
    .addr(rank_addr), .pos(row_sel), .cnt(row_cnt), .vec(row_c));

  dram_bit_gather #(.ADDR_W(ADDR_W), .N(COL_N), .CNT_W(COL_CW)) u_col (
    .addr(rank_addr), .pos(col_sel), .cnt(col_cnt), .vec(colg_c));

  // auto-precharge bit sits just above the gathered column bits
  assign col_c = {close_page, colg_c};

  dram_bank_sel #(.ADDR_W(ADDR_W)) u_bank (
    .addr(rank_addr), .close_page(close_page), .fine_bank(fine_bank),
    .bank_hash(bank_hash), .bank(bank_c), .bgroup(bg_c));

  assign pack_c = {row_c, col_c, bank_c, bg_c};

  dram_out_stage #(.W(PACK_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .d(pack_c),
    .out_valid(out_valid), .q(pack_q));

  assign {row, col, bank, bgroup} = pack_q;

  // R4
  ap_bit_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_page |-> col_c[COL_N]);
  // R8
  row_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_bits < ROW_CW'(ROW_N)) |-> ((row_c >> row_bits) == '0));
  // R8
  col_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_bits < COL_CW'(COL_N)) |-> ((colg_c >> col_bits) == '0));
  // R6
  bank_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_page && !bank_hash) |-> (bank_c == {rank_addr[9], rank_addr[8]}));
  // R7
  bg_hash_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_page && bank_hash) |->
      (bg_c == ({rank_addr[17], (fine_bank ? rank_addr[6] : rank_addr[13])}
                ^ {rank_addr[21], rank_addr[20]})));
endmodule

// File: tb/test_dram_addr_mapper.sv
`timescale 1ns/1ps
module test_dram_addr_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [33:0] rank_addr = '0;
  logic        close_page = 1'b0, fine_bank = 1'b0, bank_hash = 1'b0;
  logic [4:0]  row_bits = 5'd17;
  logic [3:0]  col_bits = 4'd10;
  logic        out_valid;
  logic [16:0] row;
  logic [10:0] col;
  logic [1:0]  bank, bgroup;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dram_addr_mapper i_dram_addr_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rank_addr(rank_addr),
    .close_page(close_page), .fine_bank(fine_bank), .bank_hash(bank_hash),
    .row_bits(row_bits), .col_bits(col_bits), .out_valid(out_valid),
    .row(row), .col(col), .bank(bank), .bgroup(bgroup));

  int rowc_t[17] = '{15,16,17,18,20,21,22,28,10,11,12,13,29,30,31,32,33};
  int rowo_t[17] = '{14,15,16,20,28,21,22,23,24,25,26,27,29,30,31,32,33};
  int colc_t[10] = '{3,4,5,14,19,23,24,25,26,27};
  int colf_t[10] = '{3,4,5,7,8,9,10,11,12,13};

  logic [16:0] e_row; logic [10:0] e_col; logic [1:0] e_bank, e_bg;

  task automatic model(input logic [33:0] a, input bit cl, input bit fi, input bit hs,
                       input int rb, input int cb);
    int nr, nc;
    nr = (rb > 17) ? 17 : rb;
    nc = (cb > 10) ? 10 : cb;
    e_row = '0; e_col = '0;
    for (int i = 0; i < nr; i++) e_row[i] = cl ? a[rowc_t[i]] : a[rowo_t[i]];
    for (int i = 0; i < nc; i++) e_col[i] = cl ? a[colc_t[i]] : (fi ? a[colf_t[i]] : a[i+3]);
    e_col[10] = cl;
    if (cl) begin
      e_bank = {a[9], a[8]};   if (hs) e_bank ^= {a[28], a[22]};
      e_bg   = {a[7], a[6]};
    end else begin
      e_bank = {a[19], a[18]}; if (hs) e_bank ^= {a[23], a[22]};
      e_bg   = {a[17], fi ? a[6] : a[13]};
    end
    if (hs) e_bg ^= {a[21], a[20]};
  endtask

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // present one input, sample one cycle later away from the edge
  task automatic apply(input logic [33:0] a, input bit cl, input bit fi, input bit hs,
                       input int rb, input int cb, input string rtag, input string ctag);
    @(negedge clk);
    rank_addr = a; close_page = cl; fine_bank = fi; bank_hash = hs;
    row_bits = 5'(rb); col_bits = 4'(cb); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(a, cl, fi, hs, rb, cb);
    cmp("R9", "out_valid", out_valid, 1);
    cmp(rtag, "row", row, e_row);
    cmp(ctag, "col", col, e_col);
    cmp("R6", "bank", bank, e_bank);
    cmp("R7", "bgroup", bgroup, e_bg);
  endtask

  task automatic t_reset;
    cmp("R1", "out_valid", out_valid, 0);
    cmp("R1", "row", row, 0);
    cmp("R1", "col", col, 0);
    cmp("R1", "bank", bank, 0);
    cmp("R1", "bgroup", bgroup, 0);
  endtask

  task automatic t_walk(input bit cl, input bit fi);
    for (int b = 0; b < 34; b++)
      apply(34'd1 << b, cl, fi, 0, 17, 10, cl ? "R2" : "R3", cl ? "R4" : "R5");
    apply('0, cl, fi, 0, 17, 10, cl ? "R2" : "R3", cl ? "R4" : "R5");
    apply('1, cl, fi, 0, 17, 10, cl ? "R2" : "R3", cl ? "R4" : "R5");
  endtask

  task automatic t_hash;
    for (int k = 0; k < 40; k++) begin
      logic [33:0] a;
      a = {$urandom(), $urandom()};
      apply(a, k[0], k[1], k[2], 17, 10, k[0] ? "R2" : "R3", k[0] ? "R4" : "R5");
    end
  endtask

  task automatic t_counts;
    int rbs[6] = '{12, 15, 17, 20, 31, 0};
    int cbs[6] = '{7, 10, 3, 15, 10, 0};
    for (int k = 0; k < 6; k++) begin
      apply('1, 1, 0, 0, rbs[k], cbs[k], "R8", "R8");
      apply('1, 0, 1, 1, rbs[k], cbs[k], "R8", "R8");
    end
  endtask

  task automatic t_hold;
    apply(34'h2_5A5A_C3C3, 1, 0, 1, 17, 10, "R2", "R4");
    @(negedge clk);
    rank_addr = 34'h1_0F0F_3C3C; close_page = 0; bank_hash = 0;
    repeat (3) @(negedge clk);
    cmp("R9", "out_valid idle", out_valid, 0);
    cmp("R9", "row hold", row, e_row);
    cmp("R9", "col hold", col, e_col);
    cmp("R9", "bank hold", bank, e_bank);
    cmp("R9", "bgroup hold", bgroup, e_bg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_walk(1, 0);
    t_walk(0, 0);
    t_walk(0, 1);
    t_hash();
    t_counts();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule